// File: doc/BRIEF.md
# SDRAM Address Mapper with Open-Row Tracking

This block sits at the front of an SDRAM controller. It takes each request's logical address and splits it into a column, a bank and a row. Two run-time codes choose where the split falls. A page-size code sets the column width. A bank-count code sets how many bank bits sit directly above the column. Because the bank field sits directly above the column field, a linear sweep that runs off the end of a page lands in the same row of the next bank. The row in the bank it left stays open.

The block keeps one open-row register, with a valid flag, for each internal bank. Every accepted request is classified against that bank's tracker and reported one cycle later as one of three outcomes: a page hit, an activate to an idle bank, or a precharge followed by an activate. The tracker then records the new row. The block also produces the per-lane byte masks from the request direction, the byte enables and the bus-width mode. A close-all input (for example a precharge-all before refresh) and any change of configuration forget every open row. Command timing, refresh scheduling and the data path belong to other blocks.

Top module: `sdram_addr_map`

## Requirements
- R1: The page-size code p (0..3) gives a column of 8+p bits, taken from the lowest bits of the word address. In 16-bit mode the word address is the logical address, so the column starts at logical bit 0.
- R2: The bank-count code 0, 1 or 2 gives 0, 1 or 2 bank bits, taken immediately above the column. Code 3 behaves as code 2. Bank bits that are not used read as zero.
- R3: The row is the word-address bits immediately above the bank field, truncated to ROW_W bits. Higher logical bits have no effect.
- R4: In 32-bit mode (cfg_bus32=1) the word address is the logical address shifted right by one. Logical bit 0 selects the halfword: 0 uses lanes rsp_dqm[1:0] and 1 uses lanes rsp_dqm[3:2].
- R5: For a read, rsp_dqm is 4'b0000.
- R6: For a write, the active lane pair carries the inverse of req_be[1:0], with bit 0 on the lower lane of the pair, and the other pair is 2'b11. In 16-bit mode the active pair is always [1:0].
- R7: A request to a bank with no open row is reported as activate (rsp_kind=2'b01).
- R8: A request to the open row of a bank is reported as a hit (2'b00). A request to a different row is reported as precharge+activate (2'b10). In both the miss and the conflict case, the bank then holds the new row.
- R9: Banks are tracked independently. Opening or replacing a row in one bank leaves every other bank's open row unchanged, including after a page crossing into the next bank.
- R10: While close_all is high, req_ready is low, and every bank is idle afterwards.
- R11: When any configuration input differs from its value in the previous cycle, req_ready is low for that cycle and every bank is idle afterwards.
- R12: rsp_valid is high for exactly the one cycle after each cycle where req_valid and req_ready are both high. The response fields describe that request.
- R13: After reset, rsp_valid is low, req_ready is high and every bank is idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request can be taken this cycle |
| req_addr | input | ADDR_W | Logical address |
| req_write | input | 1 | 1 for write, 0 for read |
| req_be | input | 2 | Byte enables of the addressed halfword |
| cfg_bank_code | input | 2 | Bank-count code |
| cfg_page_code | input | 2 | Page-size code |
| cfg_bus32 | input | 1 | 1 selects 32-bit bus mode |
| close_all | input | 1 | Forget all open rows |
| rsp_valid | output | 1 | Classification result present |
| rsp_kind | output | 2 | 00 hit, 01 activate, 10 precharge+activate |
| rsp_bank | output | 2 | Bank address |
| rsp_row | output | ROW_W | Row address |
| rsp_col | output | 11 | Column address |
| rsp_dqm | output | 4 | Byte-lane masks, 1 = masked |

## Verification
Address sweeps run under four configurations: 4 banks with 8-bit pages in 16-bit mode, the folded bank code with 11-bit pages in 32-bit mode, 2 banks with 9-bit pages, and 1 bank with 10-bit pages. Together they separate a wrong column width, a wrong bank offset and a missed halfword shift. Within each sweep, repeats of the same row, a new row in an open bank, and a step across a page boundary and back tell hit, conflict and activate apart. They also show that a neighbouring bank kept its row. Addresses with high junk bits confirm that upper bits are ignored. Writes with mixed byte enables on both halfwords pin down the lane order of the masks. Directed sequences then confirm that close-all, a configuration flip and reset each turn a former hit into an activate.

// File: rtl/sdram_map_pkg.sv
package sdram_map_pkg;

    localparam int COL_BASE      = 8;
    localparam int MAX_COL_BITS  = 11;
    localparam int MAX_BANK_BITS = 2;
    localparam int LANE_PAIR     = 2;

    typedef enum logic [1:0] {
        ACC_HIT     = 2'b00,
        ACC_ACT     = 2'b01,
        ACC_PRE_ACT = 2'b10
    } acc_kind_e;

    typedef struct packed {
        logic [1:0] bank_code;
        logic [1:0] page_code;
        logic       bus32;
    } map_cfg_t;

    // number of column bits for a page-size code
    function automatic logic [3:0] col_bits(input logic [1:0] page_code);
        return 4'(COL_BASE) + {2'b00, page_code};
    endfunction

    // number of bank bits for a bank-count code; code 3 folds onto 2
    function automatic logic [1:0] bank_bits(input logic [1:0] bank_code);
        return (bank_code == 2'd3) ? 2'd2 : bank_code;
    endfunction

endpackage

// File: rtl/sdram_field_split.sv
module sdram_field_split
    import sdram_map_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int ROW_W  = 13
) (
    input  map_cfg_t                   cfg,
    input  logic [ADDR_W-1:0]          addr,
    output logic [MAX_COL_BITS-1:0]    col,
    output logic [MAX_BANK_BITS-1:0]   bank,
    output logic [ROW_W-1:0]           row,
    output logic                       half_sel
);

    logic [ADDR_W-1:0]        word_addr;
    logic [ADDR_W-1:0]        above_col;
    logic [ADDR_W-1:0]        above_bank;
    logic [3:0]               n_col;
    logic [1:0]               n_bank;
    logic [MAX_COL_BITS-1:0]  col_mask;
    logic [MAX_BANK_BITS-1:0] bank_mask;

    always_comb begin
        n_col      = col_bits(cfg.page_code);
        n_bank     = bank_bits(cfg.bank_code);
        word_addr  = cfg.bus32 ? (addr >> 1) : addr;
        half_sel   = cfg.bus32 & addr[0];
        col_mask   = MAX_COL_BITS'((32'd1 << n_col) - 32'd1);
        bank_mask  = MAX_BANK_BITS'((32'd1 << n_bank) - 32'd1);
        above_col  = word_addr >> n_col;
        above_bank = above_col >> n_bank;
        col        = MAX_COL_BITS'(word_addr) & col_mask;
        bank       = MAX_BANK_BITS'(above_col) & bank_mask;
        row        = ROW_W'(above_bank);
    end

endmodule

// File: rtl/sdram_row_tracker.sv
module sdram_row_tracker
    import sdram_map_pkg::*;
#(
    parameter int ROW_W  = 13,
    parameter int BANK_W = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              clear_all,
    input  logic [BANK_W-1:0] lk_bank,
    input  logic [ROW_W-1:0]  lk_row,
    input  logic              upd,
    output acc_kind_e         kind
);

    localparam int NBANK = 1 << BANK_W;

    logic [NBANK-1:0] open_vld;
    logic [ROW_W-1:0] open_row [NBANK];

    generate
        for (genvar b = 0; b < NBANK; b++) begin : g_bank
            logic             vld_q;
            logic [ROW_W-1:0] row_q;
            always_ff @(posedge clk) begin
                if (rst || clear_all) begin
                    vld_q <= 1'b0;
                    if (rst) row_q <= '0;
                end else if (upd && (lk_bank == BANK_W'(b))) begin
                    vld_q <= 1'b1;
                    row_q <= lk_row;
                end
            end
            assign open_vld[b] = vld_q;
            assign open_row[b] = row_q;
        end
    endgenerate

    always_comb begin
        if (!open_vld[lk_bank])
            kind = ACC_ACT;
        else if (open_row[lk_bank] == lk_row)
            kind = ACC_HIT;
        else
            kind = ACC_PRE_ACT;
    end

    // R10
    clear_idle_chk: assert property (@(posedge clk) disable iff (rst)
        clear_all |=> (open_vld == '0));

    // R8
    row_store_chk: assert property (@(posedge clk) disable iff (rst)
        (upd && !clear_all) |=>
            (open_vld[$past(lk_bank)] && (open_row[$past(lk_bank)] == $past(lk_row))));

endmodule

// File: rtl/sdram_lane_mask.sv
module sdram_lane_mask
    import sdram_map_pkg::*;
(
    input  logic                 wr,
    input  logic [LANE_PAIR-1:0] be,
    input  logic                 half_sel,
    output logic [3:0]           dqm
);

    always_comb begin
        if (!wr)
            dqm = 4'b0000;
        else if (half_sel)
            dqm = {~be, 2'b11};
        else
            dqm = {2'b11, ~be};
    end

endmodule

// File: rtl/sdram_addr_map.sv
module sdram_addr_map
    import sdram_map_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int ROW_W  = 13
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     req_valid,
    output logic                     req_ready,
    input  logic [ADDR_W-1:0]        req_addr,
    input  logic                     req_write,
    input  logic [1:0]               req_be,
    input  logic [1:0]               cfg_bank_code,
    input  logic [1:0]               cfg_page_code,
    input  logic                     cfg_bus32,
    input  logic                     close_all,
    output logic                     rsp_valid,
    output logic [1:0]               rsp_kind,
    output logic [1:0]               rsp_bank,
    output logic [ROW_W-1:0]         rsp_row,
    output logic [MAX_COL_BITS-1:0]  rsp_col,
    output logic [3:0]               rsp_dqm
);

    localparam int BANK_W = MAX_BANK_BITS;

    map_cfg_t                 cfg_now;
    map_cfg_t                 cfg_q;
    logic                     cfg_stale;
    logic                     accept;
    logic [MAX_COL_BITS-1:0]  f_col;
    logic [BANK_W-1:0]        f_bank;
    logic [ROW_W-1:0]         f_row;
    logic                     f_half;
    logic [3:0]               f_dqm;
    acc_kind_e                f_kind;

    assign cfg_now   = '{bank_code: cfg_bank_code, page_code: cfg_page_code, bus32: cfg_bus32};
    assign cfg_stale = (cfg_now != cfg_q);
    assign req_ready = !rst && !close_all && !cfg_stale;
    assign accept    = req_valid && req_ready;

    sdram_field_split #(.ADDR_W(ADDR_W), .ROW_W(ROW_W)) u_split (
        .cfg      (cfg_now),
        .addr     (req_addr),
        .col      (f_col),
        .bank     (f_bank),
        .row      (f_row),
        .half_sel (f_half)
    );

    sdram_row_tracker #(.ROW_W(ROW_W), .BANK_W(BANK_W)) u_track (
        .clk       (clk),
        .rst       (rst),
        .clear_all (close_all || cfg_stale),
        .lk_bank   (f_bank),
        .lk_row    (f_row),
        .upd       (accept),
        .kind      (f_kind)
    );

    sdram_lane_mask u_mask (
        .wr       (req_write),
        .be       (req_be),
        .half_sel (f_half),
        .dqm      (f_dqm)
    );

    always_ff @(posedge clk) begin
        cfg_q <= cfg_now;
        if (rst) begin
            rsp_valid <= 1'b0;
            rsp_kind  <= ACC_HIT;
            rsp_bank  <= '0;
            rsp_row   <= '0;
            rsp_col   <= '0;
            rsp_dqm   <= '0;
        end else begin
            rsp_valid <= accept;
            if (accept) begin
                rsp_kind <= f_kind;
                rsp_bank <= f_bank;
                rsp_row  <= f_row;
                rsp_col  <= f_col;
                rsp_dqm  <= f_dqm;
            end
        end
    end

    // R12
    rsp_timing_chk: assert property (@(posedge clk) disable iff (rst)
        rsp_valid == $past(req_valid && req_ready));

    // R5
    read_mask_chk: assert property (@(posedge clk) disable iff (rst)
        (rsp_valid && !$past(req_write)) |-> (rsp_dqm == 4'b0000));

    // R6
    write_pair_chk: assert property (@(posedge clk) disable iff (rst)
        (rsp_valid && $past(req_write)) |-> ((rsp_dqm[3:2] == 2'b11) || (rsp_dqm[1:0] == 2'b11)));

endmodule

// File: tb/sdram_addr_map_test.sv
module sdram_addr_map_test;

    typedef struct packed {
        logic [31:0] addr;
        logic        wr;
        logic [1:0]  be;
        logic [1:0]  bc;
        logic [1:0]  pc;
        logic        b32;
        logic [1:0]  kind;
        logic [1:0]  bank;
        logic [12:0] row;
        logic [10:0] col;
        logic [3:0]  dqm;
    } vec_t;

    localparam int NV = 14;
    localparam vec_t VECS [NV] = '{
        // cfg A: 4 banks, 8-bit page, 16-bit bus (R1 R2 R3 R7 R8 R9)
        '{32'h0000_0005, 1'b0, 2'b00, 2'd2, 2'd0, 1'b0, 2'b01, 2'd0, 13'd0, 11'h005, 4'b0000},
        '{32'h0000_00FF, 1'b0, 2'b00, 2'd2, 2'd0, 1'b0, 2'b00, 2'd0, 13'd0, 11'h0FF, 4'b0000},
        '{32'h0000_0100, 1'b1, 2'b01, 2'd2, 2'd0, 1'b0, 2'b01, 2'd1, 13'd0, 11'h000, 4'b1110},
        '{32'h0000_0405, 1'b0, 2'b00, 2'd2, 2'd0, 1'b0, 2'b10, 2'd0, 13'd1, 11'h005, 4'b0000},
        '{32'h0000_0105, 1'b0, 2'b00, 2'd2, 2'd0, 1'b0, 2'b00, 2'd1, 13'd0, 11'h005, 4'b0000},
        '{32'hFF80_0405, 1'b0, 2'b00, 2'd2, 2'd0, 1'b0, 2'b00, 2'd0, 13'd1, 11'h005, 4'b0000},
        // cfg B: code 3 folded, 11-bit page, 32-bit bus (R2 R4 R6)
        '{32'h0000_3003, 1'b1, 2'b10, 2'd3, 2'd3, 1'b1, 2'b01, 2'd3, 13'd0, 11'h001, 4'b0111},
        '{32'h0000_4002, 1'b1, 2'b11, 2'd3, 2'd3, 1'b1, 2'b01, 2'd0, 13'd1, 11'h001, 4'b1100},
        '{32'h0000_3FFF, 1'b0, 2'b00, 2'd3, 2'd3, 1'b1, 2'b00, 2'd3, 13'd0, 11'h7FF, 4'b0000},
        // cfg C: 2 banks, 9-bit page; page crossing and return (R9)
        '{32'h0000_01FF, 1'b0, 2'b00, 2'd1, 2'd1, 1'b0, 2'b01, 2'd0, 13'd0, 11'h1FF, 4'b0000},
        '{32'h0000_0200, 1'b0, 2'b00, 2'd1, 2'd1, 1'b0, 2'b01, 2'd1, 13'd0, 11'h000, 4'b0000},
        '{32'h0000_01FF, 1'b0, 2'b00, 2'd1, 2'd1, 1'b0, 2'b00, 2'd0, 13'd0, 11'h1FF, 4'b0000},
        // cfg D: 1 bank, 10-bit page
        '{32'h0000_07FF, 1'b1, 2'b00, 2'd0, 2'd2, 1'b0, 2'b01, 2'd0, 13'd1, 11'h3FF, 4'b1111},
        '{32'h0000_0C00, 1'b0, 2'b00, 2'd0, 2'd2, 1'b0, 2'b10, 2'd0, 13'd3, 11'h000, 4'b0000}
    };

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic [31:0] req_addr = '0;
    logic        req_write = 1'b0;
    logic [1:0]  req_be = '0;
    logic [1:0]  cfg_bank_code = 2'd2;
    logic [1:0]  cfg_page_code = 2'd0;
    logic        cfg_bus32 = 1'b0;
    logic        close_all = 1'b0;
    logic        rsp_valid;
    logic [1:0]  rsp_kind;
    logic [1:0]  rsp_bank;
    logic [12:0] rsp_row;
    logic [10:0] rsp_col;
    logic [3:0]  rsp_dqm;

    int total = 0;
    int bad   = 0;
    bit done  = 1'b0;

    always #10 clk = ~clk;

    sdram_addr_map uut (
        .clk           (clk),
        .rst           (rst),
        .req_valid     (req_valid),
        .req_ready     (req_ready),
        .req_addr      (req_addr),
        .req_write     (req_write),
        .req_be        (req_be),
        .cfg_bank_code (cfg_bank_code),
        .cfg_page_code (cfg_page_code),
        .cfg_bus32     (cfg_bus32),
        .close_all     (close_all),
        .rsp_valid     (rsp_valid),
        .rsp_kind      (rsp_kind),
        .rsp_bank      (rsp_bank),
        .rsp_row       (rsp_row),
        .rsp_col       (rsp_col),
        .rsp_dqm       (rsp_dqm)
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic apply(input vec_t v, input string tag);
        @(negedge clk);
        cfg_bank_code = v.bc;
        cfg_page_code = v.pc;
        cfg_bus32     = v.b32;
        req_addr      = v.addr;
        req_write     = v.wr;
        req_be        = v.be;
        req_valid     = 1'b1;
        #1;
        while (!req_ready) @(negedge clk);
        @(posedge clk);
        @(negedge clk);
        req_valid = 1'b0;
        check({tag, " R12 rsp_valid"}, 32'(rsp_valid), 32'd1);
        check({tag, " R7/R8 kind"},    32'(rsp_kind),  32'(v.kind));
        check({tag, " R2 bank"},       32'(rsp_bank),  32'(v.bank));
        check({tag, " R3 row"},        32'(rsp_row),   32'(v.row));
        check({tag, " R1/R4 col"},     32'(rsp_col),   32'(v.col));
        check({tag, " R5/R6 dqm"},     32'(rsp_dqm),   32'(v.dqm));
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            bad++;
            total++;
            $display("FAIL watchdog expired");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        vec_t d;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R13 reset state
        check("R13 rsp_valid after reset", 32'(rsp_valid), 32'd0);
        check("R13 ready after reset", 32'(req_ready), 32'd1);

        for (int i = 0; i < NV; i++) begin
            apply(VECS[i], $sformatf("vec%0d", i));
        end

        // R12: response lasts one cycle only
        @(negedge clk);
        check("R12 rsp_valid drops", 32'(rsp_valid), 32'd0);

        // R10: close_all blocks and forgets rows (cfg D, bank0 row3 open)
        d = VECS[13];
        d.kind = 2'b01;
        @(negedge clk);
        close_all = 1'b1;
        #1;
        check("R10 ready low during close_all", 32'(req_ready), 32'd0);
        @(negedge clk);
        close_all = 1'b0;
        apply(d, "R10 after close_all");
        d.kind = 2'b00;
        apply(d, "R8 reopened row hit");

        // R11: configuration flip blocks and forgets rows
        @(negedge clk);
        cfg_page_code = 2'd3;
        #1;
        check("R11 ready low on cfg change", 32'(req_ready), 32'd0);
        @(negedge clk);
        cfg_page_code = 2'd2;
        d.kind = 2'b01;
        apply(d, "R11 after cfg flip");

        // R13: reset forgets rows
        @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        check("R13 rsp_valid in reset", 32'(rsp_valid), 32'd0);
        rst = 1'b0;
        apply(d, "R13 after reset");

        done = 1'b1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule